// File: doc/BRIEF.md
# Cascaded Loadable Up-Counter

This block is a synchronous binary up-counter built from a row of identical narrow slices. Each slice holds a few count bits and acts on the rising clock edge according to four controls. An active-low clear has the highest priority. An active-low load comes next and copies a parallel value into the count. Two count enables come last. The count advances only when both enables are high, and it holds when either one is low. The default build has four 4-bit slices, giving a 16-bit count.

The two enables have different roles. The parallel enable goes to every slice at once. The chain enable passes from slice to slice: a slice gets it only when every lower slice is at all-ones and the external chain enable is high. A carry output goes high when the whole count is all-ones and the chain enable is high. That output can drive the chain enable of another counter, so counters of this kind can be stacked further.

A parameter selects how the per-slice chain enables are formed. The serial form walks through the slices one after another. The lookahead form takes each slice's enable from a single wide AND of all lower slices. Both forms behave the same at the ports.

Top module: `casc_counter`

## Requirements
- R1: While `clr_n` is low at a rising edge, `count` becomes 0 after that edge, whatever `load_n`, `en_par`, `en_chain` and `load_val` are.
- R2: With `clr_n` high and `load_n` low at a rising edge, `count` becomes `load_val` (bit i into bit i) after that edge, whatever the two enables are.
- R3: With `clr_n` and `load_n` high and both `en_par` and `en_chain` high at a rising edge, `count` becomes its previous value plus one, modulo 2^16 for the default build.
- R4: With `clr_n` and `load_n` high and `en_chain` low, `count` holds its value across the edge, and `carry_out` is low even when `count` is all-ones.
- R5: With `clr_n` and `load_n` high and `en_par` low, `count` holds its value across the edge; `carry_out` still follows R6.
- R6: `carry_out` is high exactly when `count` is all-ones (0xFFFF by default) and `en_chain` is high. It is combinational and valid in the same cycle.
- R7: Incrementing from all-ones wraps `count` to 0.
- R8: Carries pass across slice boundaries in one edge. For example, 0x000F steps to 0x0010, 0x0FFF steps to 0x1000, and 0x00FF steps to 0x0100. A slice never advances unless all lower slices are all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Count enable shared by all slices |
| en_chain | input | 1 | Count enable that also gates the carry output |
| load_val | input | SLICE_W*NSTAGES | Parallel load value |
| count | output | SLICE_W*NSTAGES | Current count |
| carry_out | output | 1 | High when count is all-ones and en_chain is high |

## Verification
The bench loads values that sit just below each slice boundary and then steps across it. A chain that fails to gate a slice would show a jump in an upper slice or a stuck lower slice. The bench also drives all sixteen control combinations with changing data. An inverted priority would let a load beat a clear, or let a count beat a load. Swapped enable roles would show as a carry that stays high while `en_chain` is low. Finally, the bench holds all-ones with each enable low in turn and then wraps. A design that gates carry with the wrong enable, or that saturates instead of wrapping, would give a wrong `carry_out` or a nonzero count after the wrap.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;

   typedef enum logic {
      CHAIN_SERIAL    = 1'b0,
      CHAIN_LOOKAHEAD = 1'b1
   } chain_mode_e;

   typedef enum logic [1:0] {
      ACT_CLEAR = 2'd0,
      ACT_LOAD  = 2'd1,
      ACT_STEP  = 2'd2,
      ACT_HOLD  = 2'd3
   } slice_act_e;

   // Fixed priority: clear, then load, then step
   function automatic slice_act_e pick_action(input logic clr_n,
                                              input logic load_n,
                                              input logic en_par,
                                              input logic en_chain);
      slice_act_e act;
      if (!clr_n)                 act = ACT_CLEAR;
      else if (!load_n)           act = ACT_LOAD;
      else if (en_par && en_chain) act = ACT_STEP;
      else                        act = ACT_HOLD;
      return act;
   endfunction

endpackage

// File: rtl/casc_cnt_slice.sv
module casc_cnt_slice
   import casc_cnt_pkg::*;
#(
   parameter int SLICE_W = 4
) (
   input  logic               clk,
   input  logic               clr_n,
   input  logic               load_n,
   input  logic               en_par,
   input  logic               en_chain,
   input  logic [SLICE_W-1:0] din,
   output logic [SLICE_W-1:0] q,
   output logic               all_ones
);

   localparam logic [SLICE_W-1:0] ONE = SLICE_W'(1);

   slice_act_e act;

   always_comb act = pick_action(clr_n, load_n, en_par, en_chain);

   always_ff @(posedge clk) begin
      unique case (act)
         ACT_CLEAR: q <= '0;
         ACT_LOAD:  q <= din;
         ACT_STEP:  q <= q + ONE;
         default:   q <= q;
      endcase
   end

   assign all_ones = &q;

endmodule

// File: rtl/casc_chain_net.sv
module casc_chain_net
   import casc_cnt_pkg::*;
#(
   parameter int          NSTAGES    = 4,
   parameter chain_mode_e CHAIN_MODE = CHAIN_SERIAL
) (
   input  logic               en_chain_in,
   input  logic [NSTAGES-1:0] all_ones,
   output logic [NSTAGES-1:0] stage_en,
   output logic               carry_out
);

   generate
      if (CHAIN_MODE == CHAIN_SERIAL) begin : g_serial
         // Enable walks upward one slice at a time
         always_comb begin
            logic acc;
            acc = en_chain_in;
            for (int k = 0; k < NSTAGES; k++) begin
               stage_en[k] = acc;
               acc         = acc & all_ones[k];
            end
            carry_out = acc;
         end
      end else begin : g_lookahead
         // Each slice sees one wide AND over every lower slice
         for (genvar k = 0; k < NSTAGES; k++) begin : g_stage
            localparam logic [NSTAGES-1:0] LOW_MASK = NSTAGES'((64'd1 << k) - 64'd1);
            assign stage_en[k] = en_chain_in & (&(all_ones | ~LOW_MASK));
         end
         assign carry_out = en_chain_in & (&all_ones);
      end
   endgenerate

endmodule

// File: rtl/casc_counter.sv
module casc_counter
   import casc_cnt_pkg::*;
#(
   parameter int          SLICE_W    = 4,
   parameter int          NSTAGES    = 4,
   parameter chain_mode_e CHAIN_MODE = CHAIN_SERIAL
) (
   input  logic                       clk,
   input  logic                       clr_n,
   input  logic                       load_n,
   input  logic                       en_par,
   input  logic                       en_chain,
   input  logic [SLICE_W*NSTAGES-1:0] load_val,
   output logic [SLICE_W*NSTAGES-1:0] count,
   output logic                       carry_out
);

   localparam int W = SLICE_W * NSTAGES;

   generate
      if (SLICE_W < 1 || SLICE_W > 32) begin : g_bad_slice
         $error("casc_counter: SLICE_W must be 1..32");
      end
      if (NSTAGES < 1 || NSTAGES > 32) begin : g_bad_stages
         $error("casc_counter: NSTAGES must be 1..32");
      end
      if (W > 1024) begin : g_bad_width
         $error("casc_counter: total width too large");
      end
   endgenerate

   logic [NSTAGES-1:0] slice_full;
   logic [NSTAGES-1:0] slice_en;

   casc_chain_net #(
      .NSTAGES    (NSTAGES),
      .CHAIN_MODE (CHAIN_MODE)
   ) u_chain (
      .en_chain_in (en_chain),
      .all_ones    (slice_full),
      .stage_en    (slice_en),
      .carry_out   (carry_out)
   );

   generate
      for (genvar s = 0; s < NSTAGES; s++) begin : g_slice
         casc_cnt_slice #(
            .SLICE_W (SLICE_W)
         ) u_slice (
            .clk      (clk),
            .clr_n    (clr_n),
            .load_n   (load_n),
            .en_par   (en_par),
            .en_chain (slice_en[s]),
            .din      (load_val[s*SLICE_W +: SLICE_W]),
            .q        (count[s*SLICE_W +: SLICE_W]),
            .all_ones (slice_full[s])
         );
      end
   endgenerate

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         clr_n,
   input logic         load_n,
   input logic         en_par,
   input logic         en_chain,
   input logic [W-1:0] load_val,
   input logic [W-1:0] count,
   input logic         carry_out
);

   // Becomes set at the first clear; before that the count is unknown
   logic armed = 1'b0;
   always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

   // R1
   clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> count == '0);

   // R2
   load_copy_chk: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !load_n) |=> count == $past(load_val));

   // R3
   step_up_chk: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && en_par && en_chain) |=> count == W'($past(count) + 1'b1));

   // R4
   chain_hold_chk: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && !en_chain) |=> count == $past(count));

   // R4
   chain_low_carry_chk: assert property (@(posedge clk) disable iff (!armed)
      !en_chain |-> !carry_out);

   // R5
   par_hold_chk: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && !en_par) |=> count == $past(count));

   // R6
   carry_full_chk: assert property (@(posedge clk) disable iff (!armed)
      carry_out |-> (count == '1));

   // R6
   carry_present_chk: assert property (@(posedge clk) disable iff (!armed)
      (en_chain && count == '1) |-> carry_out);

   // R7
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && load_n && en_par && en_chain && count == '1) |=> count == '0);

endmodule

bind casc_counter casc_counter_chk #(.W(SLICE_W*NSTAGES)) u_chk (
   .clk       (clk),
   .clr_n     (clr_n),
   .load_n    (load_n),
   .en_par    (en_par),
   .en_chain  (en_chain),
   .load_val  (load_val),
   .count     (count),
   .carry_out (carry_out)
);

// File: tb/casc_counter_tb.sv
`timescale 1ns/1ps
module casc_counter_tb;

   localparam int W    = 16;
   localparam int MASK = 32'hFFFF;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic         load_n = 1'b1;
   logic         en_par = 1'b0;
   logic         en_chain = 1'b0;
   logic [W-1:0] load_val = '0;
   logic [W-1:0] count;
   logic         carry_out;

   int n_tests = 0;
   int n_fail  = 0;
   int ref_cnt = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   casc_counter u_dut (
      .clk       (clk),
      .clr_n     (clr_n),
      .load_n    (load_n),
      .en_par    (en_par),
      .en_chain  (en_chain),
      .load_val  (load_val),
      .count     (count),
      .carry_out (carry_out)
   );

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // One clock with the given controls; checks carry before the edge and
   // the count after it against the behavioural model.
   task automatic step(input string req, input bit c, input bit l,
                       input bit ep, input bit ec, input int val);
      @(negedge clk);
      clr_n    = c;
      load_n   = l;
      en_par   = ep;
      en_chain = ec;
      load_val = W'(val);
      #1;
      if (ref_cnt >= 0)
         check({req, " carry"}, int'(carry_out),
               ((ref_cnt == MASK) && ec) ? 1 : 0);
      if (!c)           ref_cnt = 0;
      else if (!l)      ref_cnt = val & MASK;
      else if (ep && ec) ref_cnt = (ref_cnt + 1) & MASK;
      @(posedge clk);
      #1;
      check({req, " count"}, int'(count), ref_cnt);
   endtask

   initial begin
      ref_cnt = -1;
      // R1: clear wins over a pending load and both enables
      step("R1", 0, 0, 1, 1, 16'hA5A5);
      step("R1", 0, 1, 1, 1, 16'h1234);
      // R2: load with enables in every state
      step("R2", 1, 0, 1, 1, 16'h1234);
      step("R2", 1, 0, 0, 0, 16'hBEEF);
      step("R2", 1, 0, 1, 0, 16'h0007);
      // R3: plain counting
      for (int i = 0; i < 5; i++) step("R3", 1, 1, 1, 1, 0);
      // R4: chain enable low holds and masks carry
      step("R4", 1, 1, 1, 0, 0);
      step("R4", 1, 1, 0, 0, 0);
      // R5: parallel enable low holds
      step("R5", 1, 1, 0, 1, 0);
      // R8: slice boundaries
      step("R8", 1, 0, 0, 0, 16'h000F);
      step("R8", 1, 1, 1, 1, 0);
      step("R8", 1, 0, 0, 0, 16'h00FF);
      step("R8", 1, 1, 1, 1, 0);
      step("R8", 1, 0, 0, 0, 16'h0FFF);
      step("R8", 1, 1, 1, 1, 0);
      step("R8", 1, 0, 0, 0, 16'hF0FF);
      step("R8", 1, 1, 0, 1, 0);
      step("R8", 1, 1, 1, 1, 0);
      // R6 / R4 / R5 / R7 at all-ones
      step("R6", 1, 0, 0, 0, 16'hFFFF);
      step("R6", 1, 1, 0, 1, 0);
      step("R4", 1, 1, 1, 0, 0);
      step("R5", 1, 1, 0, 1, 0);
      step("R7", 1, 1, 1, 1, 0);
      step("R7", 1, 1, 1, 1, 0);
      // R8 / R7: long run across the top wrap
      step("R8", 1, 0, 1, 1, 16'hFFF0);
      for (int i = 0; i < 24; i++) step("R8", 1, 1, 1, 1, 0);
      // Every control combination with changing data
      for (int rep = 0; rep < 12; rep++) begin
         for (int m = 0; m < 16; m++) begin
            int v;
            v = int'($urandom) & MASK;
            if (rep % 3 == 0 && m == 5) v = 16'hFFFF;
            step(m[3] == 1'b0 ? "R1" : (m[2] == 1'b0 ? "R2" :
                 ((m[1] && m[0]) ? "R3" : (m[0] == 1'b0 ? "R4" : "R5"))),
                 m[3], m[2], m[1], m[0], v);
         end
         step("R6", 1, 0, 0, 0, 16'hFFFE);
         step("R6", 1, 1, 1, 1, 0);
         step("R6", 1, 1, 0, 1, 0);
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule